// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps SDRAM contents alive by producing auto-refresh cycles at a fixed, programmable rate. The rate comes from a down-counter that reloads itself. When the counter expires it raises a single internal request. The scheduler then waits until the memory path reports that no burst is in progress. At that point it takes over the SDRAM command pins and drives this sequence:

1. A precharge-all command.
2. A programmable number of idle cycles.
3. One auto-refresh command, sent to every chip select at once.
4. A programmable recovery gap.

After the recovery gap it hands the pins back.

Any access request that arrives while a refresh sequence is running is held off by a stall output. The bus cycle may already have begun, but its SDRAM command has to wait until the recovery gap has ended. Ordinary read and write command generation lives elsewhere. This block only owns the pins while it is refreshing and drives deselect at all other times.

Top module: `refsched_top`

## Requirements
- R1: While reset is low, and at the first cycle after it, the command pins are deselect ({csN,rasN,casN,weN} all ones), addr10 is low, stall is low and overrun is low.
- R2: With refreshEn high and a nonzero periodLoad P, the request is raised once every P enabled cycles. After enable rises from a disabled state, precharge-all first appears on the pins P+1 clock edges later. With no burst in the way, successive precharge-all commands are then exactly P cycles apart.
- R3: While burstActive is high, a pending request does not start a refresh, and no precharge-all is driven. The sequence starts in the first cycle that has a pending request and burstActive low, and precharge-all follows on the next cycle.
- R4: Precharge-all drives every csN low, rasN=0, casN=1, weN=0 and addr10=1. It is followed by preDelay+1 cycles of NOP (every csN low, rasN=casN=weN=1). preDelay is read as 0..3, which means 1..4 cycles.
- R5: After the precharge delay, one auto-refresh cycle drives every csN low, rasN=0, casN=0 and weN=1. It is followed by recDelay+1 NOP cycles (again 1..4), and then by deselect.
- R6: stall equals accessReq in every cycle from the start cycle up to and including the last recovery cycle. In all other cycles stall is 0.
- R7: If the counter expires while a request is still pending and is not being taken in that cycle, the expiry does not queue a second refresh. Instead, overrun goes high and stays high until reset.
- R8: Driving refreshEn low, or setting periodLoad to zero, stops the counter and drops any pending request. A refresh sequence that is already under way still runs to its end.
- R9: Outside a refresh sequence the block drives deselect, with addr10 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refreshEn | input | 1 | Enables the refresh counter |
| periodLoad | input | 16 | Reload value of the refresh counter; zero disables refresh |
| preDelay | input | 2 | Precharge-to-refresh gap, value+1 cycles |
| recDelay | input | 2 | Recovery gap after auto-refresh, value+1 cycles |
| burstActive | input | 1 | High while a memory burst is in progress |
| accessReq | input | 1 | An access is asking for the SDRAM |
| csN | output | 2 | Active-low chip selects |
| rasN | output | 1 | Active-low row strobe |
| casN | output | 1 | Active-low column strobe |
| weN | output | 1 | Active-low write enable |
| addr10 | output | 1 | Address bit 10, high for precharge-all |
| stall | output | 1 | Holds off the access path |
| overrun | output | 1 | Sticky flag for a refresh request lost while one was already pending |

## Verification
The bench runs a cycle-level model alongside the design, under random enable, period, delay, burst and access patterns. It adds directed cases on top of that.

- **Counter off by one:** a design that counts one cycle too many or too few fails the measured gap between the enable edge and the first precharge-all, and the measured spacing between successive precharge-alls.
- **Burst ignored:** holding burstActive across several expiries catches a scheduler that breaks into a burst. The same stimulus catches one that queues extra requests instead of setting overrun.
- **Enable dropped mid-sequence:** dropping enable right after a precharge-all catches a design that abandons the auto-refresh half-way, and also one that keeps a stale request alive.
- **Delay miscounts:** the per-cycle comparison exposes a delay field read with the wrong offset, and a stall released one cycle early.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // {cs, ras, cas, we}, all active low; cs is replicated on every chip select
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_PALL  = 4'b0010;
  localparam logic [3:0] CMD_AREF  = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PALL,
    ST_PREWAIT,
    ST_AREF,
    ST_RECWAIT
  } refState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic take;      // refresh sequence starts, consume the request
    logic loadDly;   // load the gap counter
    logic dlySelRec; // 1: load recovery gap, 0: load precharge gap
    logic dlyDec;    // count the gap down
  } dpStrobe_t;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int DLY_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refreshEn,
  input  logic [PERIOD_W-1:0] periodLoad,
  input  logic [DLY_W-1:0]    preDelay,
  input  logic [DLY_W-1:0]    recDelay,
  input  dpStrobe_t           strobe,
  output logic                pending,
  output logic                dlyZero,
  output logic                overrun
);

  localparam logic [PERIOD_W-1:0] CNT_ONE = PERIOD_W'(1);
  localparam logic [DLY_W-1:0]    DLY_ONE = DLY_W'(1);

  logic [PERIOD_W-1:0] periodCnt;
  logic [DLY_W-1:0]    gapCnt;
  logic                counting;
  logic                expire;

  assign counting = refreshEn && (periodLoad != '0);
  assign expire   = counting && (periodCnt == CNT_ONE);
  assign dlyZero  = (gapCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (!counting || periodCnt <= CNT_ONE)
        periodCnt <= periodLoad;
      else
        periodCnt <= periodCnt - CNT_ONE;

      if (!counting)
        pending <= 1'b0;
      else
        pending <= expire | (pending & ~strobe.take);

      if (expire && pending && !strobe.take)
        overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      gapCnt <= '0;
    else if (strobe.loadDly)
      gapCnt <= strobe.dlySelRec ? recDelay : preDelay;
    else if (strobe.dlyDec && !dlyZero)
      gapCnt <= gapCnt - DLY_ONE;
  end

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pending,
  input  logic              dlyZero,
  input  logic              burstActive,
  input  logic              accessReq,
  output dpStrobe_t         strobe,
  output logic [NUM_CS-1:0] csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              addr10,
  output logic              stall
);

  refState_t state, nextState;
  logic [3:0] cmd;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (pending && !burstActive) begin
          strobe.take = 1'b1;
          nextState   = ST_PALL;
        end
      end
      ST_PALL: begin
        strobe.loadDly = 1'b1;
        nextState      = ST_PREWAIT;
      end
      ST_PREWAIT: begin
        if (dlyZero) nextState = ST_AREF;
        else         strobe.dlyDec = 1'b1;
      end
      ST_AREF: begin
        strobe.loadDly   = 1'b1;
        strobe.dlySelRec = 1'b1;
        nextState        = ST_RECWAIT;
      end
      ST_RECWAIT: begin
        if (dlyZero) nextState = ST_IDLE;
        else         strobe.dlyDec = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      ST_PALL:    cmd = CMD_PALL;
      ST_AREF:    cmd = CMD_AREF;
      ST_PREWAIT,
      ST_RECWAIT: cmd = CMD_NOP;
      default:    cmd = CMD_DESEL;
    endcase
  end

  assign csN    = {NUM_CS{cmd[3]}};
  assign rasN   = cmd[2];
  assign casN   = cmd[1];
  assign weN    = cmd[0];
  assign addr10 = (state == ST_PALL);
  assign stall  = accessReq && ((state != ST_IDLE) || strobe.take);

endmodule

// File: rtl/refsched_top.sv
module refsched_top
  import refsched_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int DLY_W    = 2,
  parameter int NUM_CS   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refreshEn,
  input  logic [PERIOD_W-1:0] periodLoad,
  input  logic [DLY_W-1:0]    preDelay,
  input  logic [DLY_W-1:0]    recDelay,
  input  logic                burstActive,
  input  logic                accessReq,
  output logic [NUM_CS-1:0]   csN,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic                addr10,
  output logic                stall,
  output logic                overrun
);

  dpStrobe_t strobe;
  logic      pending;
  logic      dlyZero;

  refsched_dp #(.PERIOD_W(PERIOD_W), .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .periodLoad(periodLoad),
    .preDelay(preDelay), .recDelay(recDelay), .strobe(strobe),
    .pending(pending), .dlyZero(dlyZero), .overrun(overrun)
  );

  refsched_ctrl #(.NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .dlyZero(dlyZero),
    .burstActive(burstActive), .accessReq(accessReq), .strobe(strobe),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .addr10(addr10),
    .stall(stall)
  );

endmodule

// File: rtl/refsched_chk.sv
module refsched_chk (
  input logic clk,
  input logic rstN,
  input logic refreshEn,
  input logic burstActive,
  input logic accessReq,
  input logic allCsLow,
  input logic allCsHigh,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic addr10,
  input logic stall,
  input logic overrun,
  input logic pending
);

  logic isPall, isAref, isNop;
  assign isPall = allCsLow && !rasN &&  casN && !weN;
  assign isAref = allCsLow && !rasN && !casN &&  weN;
  assign isNop  = allCsLow &&  rasN &&  casN &&  weN;

  // R4
  pall_then_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    isPall |=> isNop);

  // R4
  pall_addr10_chk: assert property (@(posedge clk) disable iff (!rstN)
    isPall |-> addr10);

  // R5
  aref_then_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    isAref |=> isNop);

  // R3
  burst_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && allCsHigh) |=> !isPall);

  // R6
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> accessReq);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R8
  disable_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refreshEn |=> !pending);

endmodule

bind refsched_top refsched_chk u_chk (
  .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .burstActive(burstActive),
  .accessReq(accessReq), .allCsLow(~|csN), .allCsHigh(&csN), .rasN(rasN),
  .casN(casN), .weN(weN), .addr10(addr10), .stall(stall), .overrun(overrun),
  .pending(pending)
);

// File: tb/sim_refsched_top.sv
module sim_refsched_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic        refreshEn;
  logic [15:0] periodLoad;
  logic [1:0]  preDelay, recDelay;
  logic        burstActive, accessReq;
  logic [1:0]  csN;
  logic        rasN, casN, weN, addr10, stall, overrun;

  refsched_top u0 (
    .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .periodLoad(periodLoad),
    .preDelay(preDelay), .recDelay(recDelay), .burstActive(burstActive),
    .accessReq(accessReq), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr10(addr10), .stall(stall), .overrun(overrun)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // reference model state: 0 idle, 1 pall, 2 pre gap, 3 aref, 4 recovery gap
  int mCnt, mState, mDly;
  bit mPend, mOvr;
  logic [4:0] lastCmd;

  localparam logic [4:0] P_DESEL = 5'b11111;
  localparam logic [4:0] P_NOP   = 5'b00111;
  localparam logic [4:0] P_PALL  = 5'b00010;
  localparam logic [4:0] P_AREF  = 5'b00001;

  function automatic logic [4:0] expPins(int st);
    case (st)
      1: return P_PALL;
      3: return P_AREF;
      2, 4: return P_NOP;
      default: return P_DESEL;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mCnt = 0; mState = 0; mDly = 0; mPend = 0; mOvr = 0;
  endtask

  // called just after a negedge with inputs set; returns just after the next negedge
  task automatic cycle();
    bit active, start, expStall, expire, nextPend;
    string tag;
    #1;
    active = refreshEn && (periodLoad != 0);
    start  = (mState == 0) && mPend && !burstActive;
    lastCmd = {csN, rasN, casN, weN};
    if (mState == 1 || mState == 2)      tag = "R4";
    else if (mState == 3 || mState == 4) tag = "R5";
    else if (mPend && burstActive)       tag = "R3";
    else if (!active)                    tag = "R8";
    else                                 tag = "R9";
    check(lastCmd == expPins(mState), tag, "command pins", lastCmd, expPins(mState));
    check(addr10 == (mState == 1), tag, "addr10", addr10, (mState == 1));
    expStall = accessReq && (mState != 0 || start);
    check(stall == expStall, "R6", "stall", stall, expStall);
    check(overrun == mOvr, "R7", "overrun", overrun, mOvr);
    @(posedge clk);
    expire   = active && (mCnt == 1);
    nextPend = active && (expire || (mPend && !start));
    if (active && expire && mPend && !start) mOvr = 1;
    if (!active || mCnt <= 1) mCnt = periodLoad; else mCnt--;
    case (mState)
      0: if (start) mState = 1;
      1: begin mDly = preDelay; mState = 2; end
      2: if (mDly == 0) mState = 3; else mDly--;
      3: begin mDly = recDelay; mState = 4; end
      default: if (mDly == 0) mState = 0; else mDly--;
    endcase
    mPend = nextPend;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int first, second, nPall, nAref;
    void'($urandom(32'd4242));
    rstN = 0; refreshEn = 0; periodLoad = 16'd6; preDelay = 0; recDelay = 0;
    burstActive = 0; accessReq = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check({csN, rasN, casN, weN} == P_DESEL, "R1", "pins in reset", {csN, rasN, casN, weN}, P_DESEL);
    check(addr10 == 0 && stall == 0, "R1", "addr10/stall in reset", {addr10, stall}, 0);
    check(overrun == 0, "R1", "overrun in reset", overrun, 0);
    rstN = 1;
    modelReset();
    accessReq = 0;
    cycle(); cycle();

    // R2: first precharge-all P+1 edges after enable, then every P cycles
    refreshEn = 1;
    first = 0; second = 0;
    for (int k = 1; k <= 30; k++) begin
      cycle();
      if (lastCmd == P_PALL) begin
        if (first == 0) first = k;
        else if (second == 0) second = k;
      end
    end
    check(first == 8, "R2", "calls to first precharge-all", first, 8);
    check(second - first == 6, "R2", "precharge-all spacing", second - first, 6);

    // R3 + R7: burst blocks refresh across several expiries
    refreshEn = 0;
    repeat (12) cycle();
    periodLoad = 16'd3; refreshEn = 1; burstActive = 1; accessReq = 1;
    nPall = 0;
    repeat (20) begin cycle(); if (lastCmd == P_PALL) nPall++; end
    check(nPall == 0, "R3", "precharge-all during burst", nPall, 0);
    check(overrun == 1, "R7", "overrun after lost expiry", overrun, 1);
    burstActive = 0;
    cycle(); cycle();
    check(lastCmd == P_PALL, "R3", "precharge-all after burst end", lastCmd, P_PALL);

    // R8: enable dropped right after precharge-all, sequence completes
    preDelay = 2'd3; recDelay = 2'd3; refreshEn = 0;
    repeat (14) cycle();
    periodLoad = 16'd2; refreshEn = 1;
    lastCmd = 0;
    for (int k = 0; k < 20 && lastCmd != P_PALL; k++) cycle();
    refreshEn = 0;
    nPall = 0; nAref = 0;
    repeat (30) begin
      cycle();
      if (lastCmd == P_PALL) nPall++;
      if (lastCmd == P_AREF) nAref++;
    end
    check(nAref == 1, "R8", "auto-refresh after disable", nAref, 1);
    check(nPall == 0, "R8", "new precharge-all after disable", nPall, 0);
    // R8: zero period means disabled
    refreshEn = 1; periodLoad = 0; nPall = 0;
    repeat (30) begin cycle(); if (lastCmd == P_PALL) nPall++; end
    check(nPall == 0, "R8", "precharge-all with zero period", nPall, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 32 == 0) periodLoad = 16'($urandom % 24);
      if ($urandom % 16 == 0) preDelay = 2'($urandom % 4);
      if ($urandom % 16 == 0) recDelay = 2'($urandom % 4);
      if ($urandom % 64 == 0) refreshEn = ~refreshEn;
      if ($urandom % 6 == 0) burstActive = ~burstActive;
      accessReq = 1'($urandom % 2);
      cycle();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule